// File: doc/BRIEF.md
# Slave-Side Parallel Programming Port

This block is the target end of a parallel programming link for an on-chip nonvolatile word array. An external programmer drives one 16-bit bus made of two 8-bit ports and two active-low strobes. A falling edge on the address strobe loads a command word. Bit 0 of that word picks the operation, and the bits above it give a word address. A falling edge on the data strobe then either starts a program operation with the word on the bus, or, for a read, turns the bus around and drives the addressed word back out for as long as the strobe stays low.

The storage behaves like erasable-programmable cells. Erased bits read as 1, and a program operation can only clear bits. It takes a fixed number of cycles. When it ends, the block reads the location back. A per-operation flag shows whether the readback matched the requested word. A cumulative flag stays high only while every operation since programming mode was last entered has passed. An active-low step input makes the stored address advance after each access, so a run of consecutive words needs only one address transfer.

Both strobes are asynchronous. Each passes through a two-flop synchroniser before its edges are detected. Leaving programming mode halts all activity.

Top module: `slave_prog_if`

## Requirements
- R1: After reset, `busy`, `port_oe`, `verify_ok` and `all_ok` are 0 and every stored word reads 16'hFFFF.
- R2: A rising edge on `prog_mode` sets `all_ok` to 1 and `verify_ok` to 0. While `prog_mode` is low, both strobes are ignored and `busy` and `port_oe` stay 0.
- R3: A synchronised falling edge on `addr_stb_n` loads a command from `port_in`. Bit 0 selects the mode (1 = program, 0 = read-back). Bits 15:1 give the word address. An address is in range when it is below 2**ADDR_W.
- R4: In program mode, a data-strobe fall captures `port_in`. `busy` is 1 from the third clock edge after the fall. At edge 3+PROG_LAT the location becomes old AND new, `busy` drops, and `verify_ok` shows whether the stored word equals the data.
- R5: A program that asks for a 1 where the location already holds 0 leaves that bit at 0 and gives `verify_ok` = 0.
- R6: The first failing operation clears `all_ok`. It stays 0 through later passing operations until programming mode is entered again.
- R7: A program to an out-of-range address writes nothing and counts as a failure for both flags.
- R8: In read-back mode, from the third edge after a data-strobe fall, `port_oe` is 1 and `port_out` holds the addressed word. From the third edge after the strobe rises, `port_oe` is 0.
- R9: With `inc_n` low, the address advances by one after each completed program and after each read-back strobe rises. With `inc_n` high, the address holds.
- R10: Strobe edges that arrive while a program operation is busy are ignored.
- R11: Read-back of an out-of-range address drives 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_mode | input | 1 | Programming mode enable |
| port_in | input | PORT_W | Command or data word from the two 8-bit ports |
| addr_stb_n | input | 1 | Address/command strobe, active low, asynchronous |
| data_stb_n | input | 1 | Data/program strobe, active low, asynchronous |
| inc_n | input | 1 | Address auto-step enable, active low |
| port_out | output | PORT_W | Word driven back during read-back |
| port_oe | output | 1 | Drive enable for `port_out` |
| busy | output | 1 | Program operation in progress |
| verify_ok | output | 1 | Result of the last program operation |
| all_ok | output | 1 | All operations passed since mode entry |

## Verification
A table of program words is walked in order. It holds a write to an erased word, a second write that clears only bits already set, a write that tries to set bits again, writes at address 0-region, mid-range and the top word, and one just past the top. Together these separate the AND-merge from a plain overwrite, a pass from a failure, and an in-range address from an out-of-range one. Directed runs count edges to pin down the latency, fire a second strobe during a busy window, step through consecutive words with one address load and then hold with the step input high, and strobe while the mode is off before re-entering it.

// File: rtl/slave_prog_if_pkg.sv
package slave_prog_if_pkg;

  parameter int unsigned PORT_W = 16;
  localparam int unsigned AFLD_W = PORT_W - 1;

  typedef logic [PORT_W-1:0] word_t;
  typedef logic [AFLD_W-1:0] waddr_t;

  typedef enum logic {
    CMD_READBACK = 1'b0,
    CMD_PROGRAM  = 1'b1
  } cmd_mode_e;

  // address lies inside the implemented array
  function automatic logic addr_in_range(input waddr_t a, input int unsigned depth);
    return 32'(a) < depth;
  endfunction

  // cells can only be cleared by programming
  function automatic word_t cell_merge(input word_t stored, input word_t req);
    return stored & req;
  endfunction

  function automatic logic readback_matches(input word_t got, input word_t req);
    return got == req;
  endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fell,
  output logic rose
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= strobe_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain[STAGES-1];

  assign fell = last_q & ~chain[STAGES-1];
  assign rose = ~last_q & chain[STAGES-1];
endmodule

// File: rtl/prog_array.sv
module prog_array
  import slave_prog_if_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] idx,
  input  word_t             wr_word,
  output word_t             rd_word
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  word_t cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[idx] <= wr_word;
    end
  end

  assign rd_word = cells[idx];
endmodule

// File: rtl/slave_prog_if.sv
module slave_prog_if
  import slave_prog_if_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned PROG_LAT = 4,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic [PORT_W-1:0] port_in,
  input  logic              addr_stb_n,
  input  logic              data_stb_n,
  input  logic              inc_n,
  output logic [PORT_W-1:0] port_out,
  output logic              port_oe,
  output logic              busy,
  output logic              verify_ok,
  output logic              all_ok
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned CNT_W = (PROG_LAT > 1) ? $clog2(PROG_LAT) : 1;

  // named internal events, also seen by the bound checker
  logic astb_fell, astb_rose, dstb_fell, dstb_rose;
  logic enter_evt, addr_load, start_evt, done_evt;
  logic dump_start, dump_end, step_evt, in_rng, op_pass;

  logic       mode_d1;
  waddr_t     addr_q;
  cmd_mode_e  cmd_q;
  word_t      data_q;
  logic       busy_q, oe_q, ver_q, all_q;
  logic [CNT_W-1:0] cnt_q;
  word_t      out_q, rd_word, merged;

  strobe_edge #(.STAGES(SYNC_N)) u_astb (
    .clk(clk), .rst_n(rst_n), .strobe_n(addr_stb_n),
    .fell(astb_fell), .rose(astb_rose));

  strobe_edge #(.STAGES(SYNC_N)) u_dstb (
    .clk(clk), .rst_n(rst_n), .strobe_n(data_stb_n),
    .fell(dstb_fell), .rose(dstb_rose));

  assign in_rng     = addr_in_range(addr_q, DEPTH);
  assign merged     = cell_merge(rd_word, data_q);
  assign op_pass    = in_rng & readback_matches(merged, data_q);

  assign enter_evt  = prog_mode & ~mode_d1;
  assign addr_load  = prog_mode & astb_fell & ~busy_q & ~oe_q;
  assign start_evt  = prog_mode & dstb_fell & ~busy_q & (cmd_q == CMD_PROGRAM);
  assign dump_start = prog_mode & dstb_fell & ~busy_q & ~oe_q & (cmd_q == CMD_READBACK);
  assign done_evt   = prog_mode & busy_q & (cnt_q == '0);
  assign dump_end   = prog_mode & oe_q & dstb_rose;
  assign step_evt   = ~inc_n & (done_evt | dump_end);

  prog_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(done_evt & in_rng),
    .idx(addr_q[ADDR_W-1:0]),
    .wr_word(merged),
    .rd_word(rd_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_d1 <= 1'b0;
    else        mode_d1 <= prog_mode;
  end

  // address and command register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cmd_q  <= CMD_READBACK;
    end else if (addr_load) begin
      addr_q <= port_in[PORT_W-1:1];
      cmd_q  <= cmd_mode_e'(port_in[0]);
    end else if (step_evt) begin
      addr_q <= addr_q + 1'b1;
    end
  end

  // program sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
      ver_q  <= 1'b0;
      all_q  <= 1'b0;
    end else if (!prog_mode) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (enter_evt) begin
        all_q <= 1'b1;
        ver_q <= 1'b0;
      end
      if (start_evt) begin
        data_q <= port_in;
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(PROG_LAT - 1);
        ver_q  <= 1'b0;
      end else if (done_evt) begin
        busy_q <= 1'b0;
        ver_q  <= op_pass;
        if (!op_pass) all_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // read-back driver
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      out_q <= '0;
    end else if (!prog_mode) begin
      oe_q <= 1'b0;
    end else if (dump_start) begin
      oe_q  <= 1'b1;
      out_q <= in_rng ? rd_word : '1;
    end else if (dump_end) begin
      oe_q <= 1'b0;
    end
  end

  assign port_out  = out_q;
  assign port_oe   = oe_q;
  assign busy      = busy_q;
  assign verify_ok = ver_q;
  assign all_ok    = all_q;
endmodule

// File: rtl/slave_prog_if_chk.sv
module slave_prog_if_chk (
  input logic clk,
  input logic rst_n,
  input logic prog_mode,
  input logic busy,
  input logic port_oe,
  input logic verify_ok,
  input logic all_ok,
  input logic enter_evt,
  input logic start_evt,
  input logic done_evt,
  input logic in_rng,
  input logic cmd_prog
);
  assert_oe_readback_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    port_oe |-> !cmd_prog);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && port_oe));

  assert_verify_from_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(verify_ok) |-> $past(done_evt));

  assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  assert_cum_only_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_ok) |-> $past(enter_evt));

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> (!busy && !port_oe));

  assert_range_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !in_rng) |=> (!verify_ok && !all_ok));
endmodule

bind slave_prog_if slave_prog_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .busy(busy),
  .port_oe(port_oe), .verify_ok(verify_ok), .all_ok(all_ok),
  .enter_evt(enter_evt), .start_evt(start_evt), .done_evt(done_evt),
  .in_rng(in_rng), .cmd_prog(cmd_q == slave_prog_if_pkg::CMD_PROGRAM));

// File: tb/slave_prog_if_test.sv
`timescale 1ns/1ps
module slave_prog_if_test;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_mode = 1'b0;
  logic [15:0] port_in = '0;
  logic        addr_stb_n = 1'b1;
  logic        data_stb_n = 1'b1;
  logic        inc_n = 1'b1;
  logic [15:0] port_out;
  logic        port_oe, busy, verify_ok, all_ok;

  int total = 0;
  int fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  slave_prog_if #(.ADDR_W(6), .PROG_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .port_in(port_in),
    .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n), .inc_n(inc_n),
    .port_out(port_out), .port_oe(port_oe), .busy(busy),
    .verify_ok(verify_ok), .all_ok(all_ok));

  typedef struct packed {
    logic [14:0] addr;
    logic [15:0] data;
    logic        ok;
    logic [15:0] rb;
  } vec_t;

  // address, program word, expected verify, expected read-back afterwards
  localparam vec_t VECS [0:5] = '{
    '{15'd3,  16'hA5F0, 1'b1, 16'hA5F0},
    '{15'd3,  16'h2550, 1'b1, 16'h2550},
    '{15'd3,  16'hFFFF, 1'b0, 16'h2550},
    '{15'd10, 16'h0000, 1'b1, 16'h0000},
    '{15'd63, 16'h1234, 1'b1, 16'h1234},
    '{15'd64, 16'h0000, 1'b0, 16'hFFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [14:0] a, input logic prog);
    @(negedge clk);
    port_in = {a, prog};
    addr_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    addr_stb_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_program(input logic [15:0] d);
    @(negedge clk);
    port_in = d;
    data_stb_n = 1'b0;
    repeat (3) @(negedge clk);
    data_stb_n = 1'b1;
    repeat (LAT + 6) @(negedge clk);
  endtask

  task automatic do_readback(input string tag, input logic [15:0] exp);
    @(negedge clk);
    data_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    check({tag, " oe during strobe"}, 32'(port_oe), 32'd1);
    check({tag, " word"}, 32'(port_out), 32'(exp));
    data_stb_n = 1'b1;
    repeat (4) @(negedge clk);
    check({tag, " oe released"}, 32'(port_oe), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
      $finish;
    end
  end

  initial begin : main
    logic run_ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 oe", 32'(port_oe), 0);
    check("R1 verify", 32'(verify_ok), 0);
    check("R1 all_ok", 32'(all_ok), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 mode entry
    prog_mode = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 all_ok on entry", 32'(all_ok), 1);
    check("R2 verify on entry", 32'(verify_ok), 0);

    // R1 erased state via read-back (R3 mode bit 0 = read-back)
    send_cmd(15'd7, 1'b0);
    do_readback("R1 erased", 16'hFFFF);

    // table walk: R3 R4 R5 R6 R7 R11
    run_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      send_cmd(VECS[i].addr, 1'b1);
      do_program(VECS[i].data);
      check($sformatf("R4/R5/R7 verify vec%0d", i), 32'(verify_ok), 32'(VECS[i].ok));
      run_ok = run_ok & VECS[i].ok;
      check($sformatf("R6 all_ok vec%0d", i), 32'(all_ok), 32'(run_ok));
      send_cmd(VECS[i].addr, 1'b0);
      do_readback($sformatf("R8/R11 vec%0d", i), VECS[i].rb);
    end

    // R4 exact latency
    send_cmd(15'd50, 1'b1);
    @(negedge clk);
    port_in = 16'h0F0F;
    data_stb_n = 1'b0;
    @(negedge clk); data_stb_n = 1'b1;
    @(negedge clk);
    check("R4 busy not yet at edge 2", 32'(busy), 0);
    @(negedge clk);
    check("R4 busy at edge 3", 32'(busy), 1);
    repeat (3) @(negedge clk);
    check("R4 verify low at edge 6", 32'(verify_ok), 0);
    check("R4 busy at edge 6", 32'(busy), 1);
    @(negedge clk);
    check("R4 verify at edge 7", 32'(verify_ok), 1);
    check("R4 busy done at edge 7", 32'(busy), 0);
    repeat (4) @(negedge clk);

    // R10 strobe while busy is ignored
    send_cmd(15'd30, 1'b1);
    @(negedge clk);
    port_in = 16'h00FF;
    data_stb_n = 1'b0;
    @(negedge clk); data_stb_n = 1'b1;
    repeat (2) @(negedge clk);
    port_in = 16'h0000;
    data_stb_n = 1'b0;
    repeat (2) @(negedge clk);
    data_stb_n = 1'b1;
    repeat (LAT + 8) @(negedge clk);
    check("R10 second op not started", 32'(busy), 0);
    send_cmd(15'd30, 1'b0);
    do_readback("R10 word kept", 16'h00FF);

    // R9 auto-increment
    inc_n = 1'b0;
    send_cmd(15'd20, 1'b1);
    do_program(16'h1111);
    do_program(16'h2222);
    do_program(16'h3333);
    send_cmd(15'd20, 1'b0);
    do_readback("R9 step word 20", 16'h1111);
    do_readback("R9 step word 21", 16'h2222);
    inc_n = 1'b1;
    do_readback("R9 hold word 22 a", 16'h3333);
    do_readback("R9 hold word 22 b", 16'h3333);

    // R2 strobes ignored with mode off, then re-entry
    send_cmd(15'd40, 1'b1);
    prog_mode = 1'b0;
    repeat (2) @(negedge clk);
    port_in = 16'h0000;
    data_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 no busy with mode off", 32'(busy), 0);
    data_stb_n = 1'b1;
    repeat (LAT + 6) @(negedge clk);
    prog_mode = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 all_ok set on re-entry", 32'(all_ok), 1);
    check("R2 verify cleared on re-entry", 32'(verify_ok), 0);
    send_cmd(15'd40, 1'b0);
    do_readback("R2 word untouched", 16'hFFFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end
endmodule